// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates nine interrupt sources for an 8-bit microcontroller core. It turns each source into a pending flag and masks the flags with per-source enables and a global enable. At each instruction boundary that the core signals, it picks one winner. The core receives a one-cycle take strobe and an 8-bit vector address, and branches there.

Each source carries one priority bit, which splits service into a high level and a low level. A high request may preempt a low routine and nothing else. A low request may never preempt. A two-bit active-level record tracks nesting, and a return pulse from the core pops it.

The two timer-overflow flags are latched inside the block and cleared when their vector is taken. The two external pins are latched the same way when they are in edge mode. The other five sources are level requests that their peripherals clear.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Source index s maps to vector 8*k+3, where k is the slot for that source. The slots are: power monitor 8, ext0 0, ADC 6, timer0 1, ext1 2, timer1 3, serial interface 7, UART 4, timer2 5. The source indices 0..8, in that list order, are also the bit positions used in `prio_i`.
- R2: When several requests of the same level are eligible, the lowest source index wins.
- R3: When `en_main_i[7]` is 0, no vector is taken, whatever the other enables hold.
- R4: A source whose enable bit is 0 is never taken. The enable bits in `en_main_i` are: bit0 ext0, bit1 timer0, bit2 ext1, bit3 timer1, bit4 UART, bit5 timer2, bit6 ADC. In `en_aux_i`, bit1 is the power monitor and bit0 is the serial interface.
- R5: An eligible high-priority request (its `prio_i` bit is 1) wins over any low-priority request, whatever their indices.
- R6: A low request is taken only when no routine is active. A high request is taken only when no high routine is active. `active_o[1]` marks an active high routine and `active_o[0]` an active low routine. `reti_i` clears the high bit if it is set, and otherwise clears the low bit.
- R7: Taking the vector of timer0, timer1, or of an external input in edge mode clears that latched flag. A level request that is still asserted stays pending after it is served.
- R8: With `ext_edge_i[n]` at 1, the external input n sets its flag on a falling edge between two samples taken on consecutive cycles, and one edge gives one service. With `ext_edge_i[n]` at 0, the request is pending for as long as the pin is low.
- R9: A vector is taken only in the cycle after `boundary_i` was high. `take_o` is high for that one cycle, and `vec_o` holds its value until the next take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction-boundary strobe; arbitration happens in this cycle |
| reti_i | input | 1 | Return-from-interrupt pulse |
| lvl_req_i | input | 5 | Level requests: power monitor, ADC, serial interface, UART, timer2 (bits 0..4) |
| tmr_ovf_i | input | 2 | Timer0 / timer1 overflow pulses |
| ext_pin_ni | input | 2 | External interrupt pins 0 / 1, active low |
| ext_edge_i | input | 2 | Trigger type per external pin: 1 edge, 0 level |
| en_main_i | input | 8 | Global enable (bit 7) and seven source enables |
| en_aux_i | input | 2 | Power monitor (bit 1) and serial interface (bit 0) enables |
| prio_i | input | 9 | Priority per source index, 1 = high |
| take_o | output | 1 | One-cycle vector-taken strobe |
| vec_o | output | 8 | Vector address of the last taken interrupt |
| active_o | output | 2 | Active routine levels: bit1 high, bit0 low |

## Verification
If the level record holds a wrong value, the effect shows at the very next boundary. Either a take is blocked, seen as `take_o` staying low, or a forbidden preemption gets through. `active_o` exposes the record one cycle after each push or pop. A flag that is not cleared, or is cleared wrongly, shows as a repeated or missing take at the boundary after the following return. A wrong order or a wrong slot shows in `vec_o` in the same cycle as the take.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 9;
  localparam int IDX_W = $clog2(NSRC);

  // source indices, highest precedence first
  localparam int S_PSM  = 0;
  localparam int S_EXT0 = 1;
  localparam int S_ADC  = 2;
  localparam int S_TMR0 = 3;
  localparam int S_EXT1 = 4;
  localparam int S_TMR1 = 5;
  localparam int S_SER  = 6;
  localparam int S_UART = 7;
  localparam int S_TMR2 = 8;

  function automatic logic [7:0] vec_of(input logic [IDX_W-1:0] idx);
    logic [4:0] slot;
    case (idx)
      IDX_W'(S_PSM):  slot = 5'd8;
      IDX_W'(S_EXT0): slot = 5'd0;
      IDX_W'(S_ADC):  slot = 5'd6;
      IDX_W'(S_TMR0): slot = 5'd1;
      IDX_W'(S_EXT1): slot = 5'd2;
      IDX_W'(S_TMR1): slot = 5'd3;
      IDX_W'(S_SER):  slot = 5'd7;
      IDX_W'(S_UART): slot = 5'd4;
      default:        slot = 5'd5;
    endcase
    return {slot, 3'b011};
  endfunction
endpackage

// File: rtl/irq_src_flags.sv
module irq_src_flags
  import irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [4:0]      lvl_req_i,
  input  logic [1:0]      tmr_ovf_i,
  input  logic [1:0]      ext_pin_ni,
  input  logic [1:0]      ext_edge_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flag_o
);
  logic [1:0] ext_flag, tmr_flag;

  for (genvar g = 0; g < 2; g++) begin : g_pair
    localparam int EXT_POS = 3 * g + 1;
    localparam int TMR_POS = 2 * g + 3;
    logic s1_q, s2_q, fall;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= ext_pin_ni[g];
        s2_q <= s1_q;
      end
    end
    assign fall = s2_q & ~s1_q;

    // a new event in the clearing cycle wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ext_flag[g] <= 1'b0;
        tmr_flag[g] <= 1'b0;
      end else begin
        ext_flag[g] <= ext_edge_i[g] ? (fall | (ext_flag[g] & ~clr_i[EXT_POS])) : ~s1_q;
        tmr_flag[g] <= tmr_ovf_i[g] | (tmr_flag[g] & ~clr_i[TMR_POS]);
      end
    end

    a_r7_tmr_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[TMR_POS] && !tmr_ovf_i[g]) |=> !tmr_flag[g]);
  end

  always_comb begin
    flag_o         = '0;
    flag_o[S_PSM]  = lvl_req_i[0];
    flag_o[S_EXT0] = ext_flag[0];
    flag_o[S_ADC]  = lvl_req_i[1];
    flag_o[S_TMR0] = tmr_flag[0];
    flag_o[S_EXT1] = ext_flag[1];
    flag_o[S_TMR1] = tmr_flag[1];
    flag_o[S_SER]  = lvl_req_i[2];
    flag_o[S_UART] = lvl_req_i[3];
    flag_o[S_TMR2] = lvl_req_i[4];
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N = 9,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_hi_i,
  input  logic       push_lo_i,
  input  logic       pop_i,
  output logic [1:0] act_o
);
  logic [1:0] act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (pop_i) begin
      if (act_q[1]) act_d[1] = 1'b0;
      else          act_d[0] = 1'b0;
    end
    if (push_hi_i) act_d[1] = 1'b1;
    if (push_lo_i) act_d[0] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 2'b00;
    else         act_q <= act_d;
  end

  assign act_o = act_q;

  a_r6_pop_high_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && act_q[1] && !push_hi_i && !push_lo_i) |=> (!act_q[1] && act_q[0] == $past(act_q[0])));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            boundary_i,
  input  logic            reti_i,
  input  logic [4:0]      lvl_req_i,
  input  logic [1:0]      tmr_ovf_i,
  input  logic [1:0]      ext_pin_ni,
  input  logic [1:0]      ext_edge_i,
  input  logic [7:0]      en_main_i,
  input  logic [1:0]      en_aux_i,
  input  logic [NSRC-1:0] prio_i,
  output logic            take_o,
  output logic [7:0]      vec_o,
  output logic [1:0]      active_o
);
  logic [NSRC-1:0]  flag, en_vec, pend, clr;
  logic             hi_any, lo_any, hi_go, lo_go, take_d;
  logic [IDX_W-1:0] hi_idx, lo_idx, win_idx;
  logic [1:0]       act;
  logic             take_q;
  logic [7:0]       vec_q;

  irq_src_flags u_flags (
    .clk_i, .rst_ni,
    .lvl_req_i, .tmr_ovf_i, .ext_pin_ni, .ext_edge_i,
    .clr_i (clr),
    .flag_o(flag)
  );

  always_comb begin
    en_vec         = '0;
    en_vec[S_PSM]  = en_aux_i[1];
    en_vec[S_EXT0] = en_main_i[0];
    en_vec[S_ADC]  = en_main_i[6];
    en_vec[S_TMR0] = en_main_i[1];
    en_vec[S_EXT1] = en_main_i[2];
    en_vec[S_TMR1] = en_main_i[3];
    en_vec[S_SER]  = en_aux_i[0];
    en_vec[S_UART] = en_main_i[4];
    en_vec[S_TMR2] = en_main_i[5];
  end

  assign pend = flag & en_vec & {NSRC{en_main_i[7]}};

  irq_pick #(.N(NSRC), .W(IDX_W)) u_pick_hi (
    .req_i(pend & prio_i), .any_o(hi_any), .idx_o(hi_idx));
  irq_pick #(.N(NSRC), .W(IDX_W)) u_pick_lo (
    .req_i(pend & ~prio_i), .any_o(lo_any), .idx_o(lo_idx));

  assign hi_go   = boundary_i & hi_any & ~act[1];
  assign lo_go   = boundary_i & ~hi_go & lo_any & (act == 2'b00);
  assign take_d  = hi_go | lo_go;
  assign win_idx = hi_go ? hi_idx : lo_idx;

  always_comb begin
    clr = '0;
    if (take_d) clr[win_idx] = 1'b1;
  end

  irq_level_stack u_stack (
    .clk_i, .rst_ni,
    .push_hi_i(hi_go),
    .push_lo_i(lo_go),
    .pop_i    (reti_i),
    .act_o    (act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      vec_q  <= 8'h00;
    end else begin
      take_q <= take_d;
      if (take_d) vec_q <= vec_of(win_idx);
    end
  end

  assign take_o   = take_q;
  assign vec_o    = vec_q;
  assign active_o = act;

  a_r9_take_after_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(boundary_i));
  a_r9_vec_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |=> (take_o || $stable(vec_o)));
  a_r3_global_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_main_i[7] |=> !take_o);
  a_r6_no_hi_over_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && active_o[1]) |=> !take_o);
  a_r1_vec_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (vec_o[2:0] == 3'b011));
endmodule

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       boundary_i, reti_i;
  logic [4:0] lvl_req_i;
  logic [1:0] tmr_ovf_i, ext_pin_ni, ext_edge_i, en_aux_i;
  logic [7:0] en_main_i;
  logic [8:0] prio_i;
  logic       take_o;
  logic [7:0] vec_o;
  logic [1:0] active_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  irq_vec_ctrl u_irq_vec_ctrl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_vec(input int s);
    int slot;
    case (s)
      0: slot = 8; 1: slot = 0; 2: slot = 6; 3: slot = 1; 4: slot = 2;
      5: slot = 3; 6: slot = 7; 7: slot = 4; default: slot = 5;
    endcase
    return 8'(8 * slot + 3);
  endfunction

  task automatic idle_inputs();
    boundary_i = 0; reti_i = 0; lvl_req_i = '0; tmr_ovf_i = '0;
    ext_pin_ni = 2'b11; ext_edge_i = 2'b00; en_main_i = 8'hFF; en_aux_i = 2'b11; prio_i = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    @(negedge clk_i) rst_ni = 0;
    @(negedge clk_i) rst_ni = 1;
  endtask

  task automatic raise(input int s);
    case (s)
      0: lvl_req_i[0] = 1;
      1: ext_pin_ni[0] = 0;
      2: lvl_req_i[1] = 1;
      3: begin tmr_ovf_i[0] = 1; @(negedge clk_i); tmr_ovf_i[0] = 0; end
      4: ext_pin_ni[1] = 0;
      5: begin tmr_ovf_i[1] = 1; @(negedge clk_i); tmr_ovf_i[1] = 0; end
      6: lvl_req_i[2] = 1;
      7: lvl_req_i[3] = 1;
      default: lvl_req_i[4] = 1;
    endcase
  endtask

  task automatic mask(input int s);
    case (s)
      0: en_aux_i[1] = 0; 1: en_main_i[0] = 0; 2: en_main_i[6] = 0;
      3: en_main_i[1] = 0; 4: en_main_i[2] = 0; 5: en_main_i[3] = 0;
      6: en_aux_i[0] = 0; 7: en_main_i[4] = 0; default: en_main_i[5] = 0;
    endcase
  endtask

  task automatic settle();
    repeat (3) @(negedge clk_i);
  endtask

  task automatic bnd();
    boundary_i = 1; @(negedge clk_i); boundary_i = 0;
  endtask

  task automatic ret();
    reti_i = 1; @(negedge clk_i); reti_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    do_reset();
    check("R9 reset take", 32'(take_o), 0);
    check("R1 reset vec", 32'(vec_o), 0);
    check("R6 reset active", 32'(active_o), 0);

    // R1: each source alone, both levels
    for (int s = 0; s < 9; s++) begin
      for (int p = 0; p < 2; p++) begin
        do_reset();
        prio_i[s] = p[0];
        raise(s); settle(); bnd();
        check("R1 take", 32'(take_o), 1);
        check("R1 vector", 32'(vec_o), 32'(exp_vec(s)));
        check("R6 level pushed", 32'(active_o), p ? 2 : 1);
      end
    end

    // R4: per-source mask
    for (int s = 0; s < 9; s++) begin
      do_reset();
      mask(s); raise(s); settle(); bnd();
      check("R4 masked", 32'(take_o), 0);
    end

    // R3: global off with everything pending
    do_reset();
    en_main_i[7] = 0;
    for (int s = 0; s < 9; s++) raise(s);
    prio_i = 9'h1FF; settle(); bnd();
    check("R3 global off", 32'(take_o), 0);

    // R2 same level order, R5 high beats low
    for (int i = 0; i < 9; i++) begin
      for (int j = i + 1; j < 9; j++) begin
        for (int p = 0; p < 2; p++) begin
          do_reset();
          prio_i[i] = p[0]; prio_i[j] = p[0];
          raise(j); raise(i); settle(); bnd();
          check("R2 order", 32'(vec_o), 32'(exp_vec(i)));
        end
        do_reset();
        prio_i[j] = 1;
        raise(i); raise(j); settle(); bnd();
        check("R5 high wins", 32'(vec_o), 32'(exp_vec(j)));
      end
    end

    // R6 nesting
    do_reset();
    raise(7); settle(); bnd();
    check("R6 low taken", 32'(active_o), 1);
    bnd();
    check("R6 low over low", 32'(take_o), 0);
    prio_i[0] = 1; raise(0); settle(); bnd();
    check("R6 high preempts", 32'(vec_o), 32'h43);
    check("R6 both active", 32'(active_o), 3);
    bnd();
    check("R6 high over high", 32'(take_o), 0);
    ret();
    check("R6 pop high", 32'(active_o), 1);
    bnd();
    check("R6 high again", 32'(take_o), 1);
    ret(); ret();
    check("R6 pop all", 32'(active_o), 0);

    // R7 auto clear vs level hold
    do_reset();
    raise(3); settle(); bnd();
    check("R7 tmr0 taken", 32'(vec_o), 32'h0B);
    ret(); bnd();
    check("R7 tmr0 cleared", 32'(take_o), 0);
    do_reset();
    raise(5); settle(); bnd(); ret(); bnd();
    check("R7 tmr1 cleared", 32'(take_o), 0);
    do_reset();
    raise(7); settle(); bnd(); ret(); bnd();
    check("R7 level kept", 32'(take_o), 1);

    // R8 edge vs level trigger
    do_reset();
    ext_edge_i = 2'b11;
    raise(1); settle(); bnd();
    check("R8 edge taken", 32'(vec_o), 32'h03);
    ret(); bnd();
    check("R8 one edge once", 32'(take_o), 0);
    ret();
    ext_pin_ni[0] = 1; settle(); ext_pin_ni[0] = 0; settle(); bnd();
    check("R8 second edge", 32'(take_o), 1);
    do_reset();
    ext_edge_i = 2'b11; raise(4); settle(); bnd(); ret(); bnd();
    check("R8 edge ext1 once", 32'(take_o), 0);
    do_reset();
    raise(4); settle(); bnd(); ret(); bnd();
    check("R8 level repeats", 32'(take_o), 1);
    ret();
    ext_pin_ni[1] = 1; settle(); bnd();
    check("R8 level released", 32'(take_o), 0);

    // R9 boundary gating and held vector
    do_reset();
    raise(2); settle(); bnd();
    held = vec_o;
    check("R9 one-cycle strobe", 32'(take_o), 1);
    @(negedge clk_i);
    check("R9 strobe drops", 32'(take_o), 0);
    ret(); raise(6);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      check("R9 no take off boundary", 32'({take_o, vec_o}), 32'({1'b0, held}));
    end
    en_main_i[7] = 0; bnd();
    check("R9 vec held", 32'(vec_o), 32'(held));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule